// File: doc/BRIEF.md
# Memory-Mapped Counting Semaphore Bank

This block is a bus slave holding a bank of counting semaphores that software drives with ordinary loads and stores. Each semaphore owns a 4 KB slot in the address space, four slots to a 16 KB page, so an operating system can hand semaphores to a user process four at a time by mapping one page. Inside a slot there are two registers. The count register is a side-effect-free view of the count: reading it returns the count and writing it sets the count. The operation register turns plain bus cycles into semaphore operations. A store to it is a signal (V) that raises the count. A load from it is a wait (P) that takes one unit if one is available. The loaded word tells the processor whether the take succeeded or whether it has to back off and try again.

The bus is a simple request/acknowledge interface. A request presents address, write enable and write data for one cycle. The acknowledge follows exactly one cycle later, with read data valid in that cycle. Every read-modify-write commits on the same clock edge that raises the acknowledge. Because of this, a request issued in the very next cycle already sees the result.

Top module: `sema_bank`

## Requirements
- R1: After reset every count is zero and `ack` is low.
- R2: Each cycle with `req` high is acknowledged by `ack` high in the next cycle and only then. The read data is valid in that acknowledge cycle, and writes acknowledge with read data zero.
- R3: Address bits [15:12] select one of the 16 semaphores. Bits [13:12] pick the semaphore within a 16 KB page and bits [15:14] pick the page. Bits [31:16] are ignored. Bits [11:0] are the register offset: 0x000 is the count register and 0x008 is the operation register.
- R4: A read of the count register returns the count in bits [15:0] with bits [31:16] zero, and leaves the count unchanged.
- R5: A write of the count register sets the count to write data bits [15:0]. Bits [31:16] are ignored.
- R6: A write of the operation register increments the count by one, whatever the write data.
- R7: An increment of a count of 0xFFFF leaves it at 0xFFFF.
- R8: A read of the operation register with a non-zero count decrements the count. It returns bit 31 = 1, bits [30:16] = 0 and the count before the decrement in bits [15:0].
- R9: A read of the operation register with a count of zero returns 0x00000000 (bit 31 = 0, must wait), and the count stays zero.
- R10: Any offset other than 0x000 or 0x008 reads as zero, ignores writes and is still acknowledged.
- R11: Requests in consecutive cycles to the same semaphore take effect in issue order, each seeing the result of the one before.
- R12: An operation on one semaphore leaves every other count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transaction request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| ack | output | 1 | Acknowledge, one cycle after `req` |
| rdata | output | 32 | Read data, valid while `ack` is high |

## Verification
Two things meet in one cycle here: the acknowledge of one operation, whose update commits at that edge, and the decode of the next request, which must already read the updated count. The bench provokes this by issuing requests back to back with no idle cycle. It does so in directed P/V/P sequences on one semaphore and in long random streams that often hit the same slot. A reference model updated in issue order predicts every returned word. A stale count would show up as a wrong grant bit or a wrong pre-decrement value in the very next acknowledge.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic [1:0] {
        SEM_NOP  = 2'd0,
        SEM_LOAD = 2'd1,
        SEM_POST = 2'd2,
        SEM_TAKE = 2'd3
    } sem_op_e;

    typedef enum logic [1:0] {
        REG_NONE    = 2'd0,
        REG_CONTENT = 2'd1,
        REG_ACCESS  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/sema_decode.sv
module sema_decode
    import sema_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_SEM     = 16,
    parameter int IDX_W       = $clog2(NUM_SEM),
    parameter int SLOT_SHIFT  = 12,
    parameter int CONTENT_OFF = 0,
    parameter int ACCESS_OFF  = 8
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output reg_sel_e          sel,
    output sem_op_e           op
);

    localparam logic [SLOT_SHIFT-1:0] C_OFF = SLOT_SHIFT'(CONTENT_OFF);
    localparam logic [SLOT_SHIFT-1:0] A_OFF = SLOT_SHIFT'(ACCESS_OFF);

    logic [SLOT_SHIFT-1:0] offset;
    logic                  unused_hi;

    // R3: slot index above the offset, upper bits alias
    assign offset    = addr[SLOT_SHIFT-1:0];
    assign idx       = addr[SLOT_SHIFT +: IDX_W];
    assign unused_hi = ^addr[ADDR_W-1:SLOT_SHIFT+IDX_W];

    always_comb begin
        if (offset == C_OFF)      sel = REG_CONTENT;
        else if (offset == A_OFF) sel = REG_ACCESS;
        else                      sel = REG_NONE;
    end

    always_comb begin
        op = SEM_NOP;
        if (req) begin
            unique case (sel)
                REG_CONTENT: op = we ? SEM_LOAD : SEM_NOP;
                REG_ACCESS:  op = we ? SEM_POST : SEM_TAKE;
                default:     op = SEM_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sema_cell.sv
module sema_cell
    import sema_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  sem_op_e          op,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (hit) begin
            unique case (op)
                SEM_LOAD: cell_d.count = load_val;
                SEM_POST: if (cell_q.count != CNT_MAX) cell_d.count = cell_q.count + CNT_W'(1);
                SEM_TAKE: if (cell_q.count != '0)      cell_d.count = cell_q.count - CNT_W'(1);
                default:  cell_d = cell_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign count = cell_q.count;

    // R6
    post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == SEM_POST && count != CNT_MAX) |=> count == $past(count) + CNT_W'(1));

    // R7
    post_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == SEM_POST && count == CNT_MAX) |=> count == CNT_MAX);

    // R8
    take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == SEM_TAKE && count != '0) |=> count == $past(count) - CNT_W'(1));

    // R9
    take_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == SEM_TAKE && count == '0) |=> count == '0);

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == SEM_LOAD) |=> count == $past(load_val));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || op == SEM_NOP) |=> $stable(count));

endmodule

// File: rtl/sema_bank.sv
module sema_bank
    import sema_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_SEM     = 16,
    parameter int CNT_W       = 16,
    parameter int SLOT_SHIFT  = 12,
    parameter int CONTENT_OFF = 0,
    parameter int ACCESS_OFF  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W     = $clog2(NUM_SEM);
    localparam int GRANT_BIT = DATA_W - 1;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    logic [IDX_W-1:0]   idx;
    reg_sel_e           sel;
    sem_op_e            op;
    logic [NUM_SEM-1:0] hit;
    logic [CNT_W-1:0]   cnt [NUM_SEM];
    logic [CNT_W-1:0]   sel_cnt;
    logic               unused_wdata;
    resp_t              resp_d, resp_q;

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

    sema_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_SEM     (NUM_SEM),
        .IDX_W       (IDX_W),
        .SLOT_SHIFT  (SLOT_SHIFT),
        .CONTENT_OFF (CONTENT_OFF),
        .ACCESS_OFF  (ACCESS_OFF)
    ) u_decode (
        .req  (req),
        .we   (we),
        .addr (addr),
        .idx  (idx),
        .sel  (sel),
        .op   (op)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        assign hit[g] = (op != SEM_NOP) && (idx == IDX_W'(g));

        sema_cell #(
            .CNT_W (CNT_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit[g]),
            .op       (op),
            .load_val (wdata[CNT_W-1:0]),
            .count    (cnt[g])
        );
    end

    assign sel_cnt = cnt[idx];

    always_comb begin
        resp_d       = '0;
        resp_d.ack   = req;
        if (req && !we) begin
            unique case (sel)
                REG_CONTENT: resp_d.rdata[CNT_W-1:0] = sel_cnt;
                REG_ACCESS: begin
                    if (sel_cnt != '0) begin
                        resp_d.rdata[GRANT_BIT]   = 1'b1;
                        resp_d.rdata[CNT_W-1:0]   = sel_cnt;
                    end
                end
                default: resp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign ack   = resp_q.ack;
    assign rdata = resp_q.rdata;

    // R2
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);

    // R2
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack);

    // R2
    write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> rdata == '0);

    // R8
    grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && sel == REG_ACCESS && sel_cnt != '0)
        |=> rdata[GRANT_BIT] && rdata[CNT_W-1:0] == $past(sel_cnt));

    // R9
    deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && sel == REG_ACCESS && sel_cnt == '0) |=> rdata == '0);

    // R10
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sel == REG_NONE) |=> rdata == '0);

    // R12
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/sema_bank_tb.sv
module sema_bank_tb;

    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        ack;
    logic [31:0] rdata;

    always #10 clk = ~clk;

    sema_bank u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .we    (we),
        .addr  (addr),
        .wdata (wdata),
        .ack   (ack),
        .rdata (rdata)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [15:0] mdl [NS];
    bit          pend   = 1'b0;
    logic [31:0] pend_rd;
    string       pend_tag;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic w, input logic [31:0] a,
                                          input logic [31:0] d, output string tag);
        int          s;
        logic [11:0] off;
        logic [31:0] r;
        s   = int'(a[15:12]);
        off = a[11:0];
        r   = 32'h0;
        if (off == 12'h000) begin
            if (w) begin mdl[s] = d[15:0]; tag = "R5"; end
            else   begin r = {16'h0, mdl[s]}; tag = "R4"; end
        end else if (off == 12'h008) begin
            if (w) begin
                if (mdl[s] != 16'hFFFF) begin mdl[s] = mdl[s] + 16'd1; tag = "R6"; end
                else tag = "R7";
            end else begin
                if (mdl[s] != 16'h0) begin
                    r = {1'b1, 15'h0, mdl[s]};
                    mdl[s] = mdl[s] - 16'd1;
                    tag = "R8";
                end else tag = "R9";
            end
        end else tag = "R10";
        return r;
    endfunction

    // One cycle: check the previous request's acknowledge, then drive the next one.
    task automatic step(input bit do_req, input logic w, input logic [31:0] a,
                        input logic [31:0] d, input string ov);
        string t;
        @(negedge clk);
        if (pend) begin
            check({pend_tag, " ack"}, {31'h0, ack}, 32'h1);
            check(pend_tag, rdata, pend_rd);
        end else begin
            check("R2 idle", {31'h0, ack}, 32'h0);
        end
        if (do_req) begin
            pend_rd  = model(w, a, d, t);
            pend_tag = (ov != "") ? ov : t;
            pend     = 1'b1;
            req = 1'b1; we = w; addr = a; wdata = d;
        end else begin
            pend = 1'b0;
            req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        end
    endtask

    function automatic logic [31:0] cnt_addr(input int s);
        return {16'h0, 4'(s), 12'h000};
    endfunction

    function automatic logic [31:0] acc_addr(input int s);
        return {16'h0, 4'(s), 12'h008};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) mdl[i] = 16'h0;
        rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack", {31'h0, ack}, 32'h0);

        // R1: all counts zero after reset
        for (int s = 0; s < NS; s++) step(1, 0, cnt_addr(s), 32'h0, "R1");

        // R5: load ignores upper write bits, then R4 read
        step(1, 1, cnt_addr(3), 32'hABCD_1234, "R5");
        step(1, 0, cnt_addr(3), 32'h0, "R5");
        step(1, 0, cnt_addr(3), 32'h0, "R4");
        // R8: grant with pre-decrement count
        step(1, 0, acc_addr(3), 32'h0, "R8");
        step(1, 0, cnt_addr(3), 32'h0, "R8");
        // R9: wait on zero
        step(1, 0, acc_addr(5), 32'h0, "R9");
        step(1, 0, cnt_addr(5), 32'h0, "R9");
        // R7: saturation
        step(1, 1, cnt_addr(7), 32'h0000_FFFE, "R7");
        step(1, 1, acc_addr(7), 32'h1234_5678, "R7");
        step(1, 1, acc_addr(7), 32'hFFFF_FFFF, "R7");
        step(1, 0, cnt_addr(7), 32'h0, "R7");
        // R6: increment ignores write data
        step(1, 1, acc_addr(0), 32'hDEAD_BEEF, "R6");
        step(1, 0, cnt_addr(0), 32'h0, "R6");
        // R3: upper bits alias, page/slot split
        step(1, 1, 32'hABC0_2008, 32'h0, "R3");
        step(1, 0, 32'h0000_2000, 32'h0, "R3");
        step(1, 1, 32'h0000_D000, 32'h0000_0042, "R3");
        step(1, 0, 32'h5555_D000, 32'h0, "R3");
        step(1, 0, cnt_addr(12), 32'h0, "R3");
        // R10: hole offsets
        step(1, 1, 32'h0000_2004, 32'h0000_0055, "R10");
        step(1, 0, 32'h0000_2004, 32'h0, "R10");
        step(1, 0, 32'h0000_2FFC, 32'h0, "R10");
        step(1, 0, cnt_addr(2), 32'h0, "R10");
        // R11: back-to-back on one semaphore
        step(1, 1, cnt_addr(9), 32'h0000_0001, "R11");
        step(1, 0, acc_addr(9), 32'h0, "R11");
        step(1, 0, acc_addr(9), 32'h0, "R11");
        step(1, 1, acc_addr(9), 32'h0, "R11");
        step(1, 0, acc_addr(9), 32'h0, "R11");
        step(1, 0, cnt_addr(9), 32'h0, "R11");
        step(0, 0, 32'h0, 32'h0, "");
        // R12: every count matches the model
        for (int s = 0; s < NS; s++) step(1, 0, cnt_addr(s), 32'h0, "R12");

        // Random mix
        for (int n = 0; n < 6000; n++) begin
            logic [31:0] a, d;
            logic [11:0] off;
            int          k;
            bit          go;
            go = ($urandom % 4) != 0;
            k  = int'($urandom % 8);
            if (k < 3 || k == 7) off = 12'h000;
            else if (k < 6)      off = 12'h008;
            else                 off = 12'($urandom);
            a = {16'($urandom), 4'($urandom), off};
            d = $urandom;
            if ($urandom % 2 == 0) d[15:0] = 16'($urandom % 4);
            else if ($urandom % 8 == 0) d[15:0] = 16'hFFFF;
            step(go, 1'($urandom), a, d, "");
        end

        step(0, 0, 32'h0, 32'h0, "");
        for (int s = 0; s < NS; s++) step(1, 0, cnt_addr(s), 32'h0, "R12");
        step(0, 0, 32'h0, 32'h0, "");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule